// File: doc/BRIEF.md
# Fifteen-Level Prioritised Interrupt Request Controller

This block gathers up to fifteen interrupt sources, numbered 1 to 15, into one 4-bit request level for a processor. Each source gives a single-cycle pulse that latches a pending bit. A mask register hides individual levels. While the test enable is high, a force register is merged into the request set. The block scans the active set from the top level downwards and registers the highest active level as the request output. A value of 0 means no request.

The processor acknowledges a request by presenting a level on the acknowledge port. In test mode, a forced bit at that level is retired before the pending bit. A small register port gives access to the state:

- read access to pending, mask and force;
- a write-only clear register.

Any write that sets bits reserved for the selected register raises a one-cycle parity error pulse. Bit 0 of every vector is unused.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request level is 0, the error pulse is low, and pending, mask and force all read as 0.
- R2: The active set is (pending OR force while the test enable is high) AND NOT mask, restricted to bits 15..1. Bit 0 is never stored and never requested. Force bits are ignored while the test enable is low.
- R3: The request level is the index of the highest bit of the active set, or 0 when the set is empty. It is registered and follows a change of the active set one clock later.
- R4: A pulse on source bit L (1..15) sets pending bit L. A set has priority over an acknowledge or a clear write to the same bit in the same cycle.
- R5: An acknowledge of level L with the test enable high and force bit L set clears only force bit L. In every other case it clears pending bit L. An acknowledge of level 0 has no effect.
- R6: A write to select 2 (clear) clears every pending bit 15..1 whose data bit is 1, and leaves the other pending bits unchanged.
- R7: A write to select 1 (mask) stores data bits 14..1 only. Mask bit 15 always reads 0, so level 15 cannot be masked.
- R8: A write to select 3 (force) stores data bits 15..1 only while the test enable is high. Otherwise the write leaves the force register unchanged.
- R9: The error output pulses high for one cycle, in the cycle after the write, in two cases:
  - a mask write with any of data bits 31..15 or bit 0 set;
  - a clear or force write with any of data bits 31..16 or bit 0 set.
  The permitted bits of such a write still take effect.
- R10: The register selects are 0 = pending, 1 = mask, 2 = clear, 3 = force. The read data shows the selected register zero-extended, with no clock delay, and select 2 reads as 0. A write to select 0 is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_pulse | input | 16 | Source pulses, bit L sets pending level L; bit 0 unused |
| test_en | input | 1 | Test-mode enable for the force register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data of the selected register |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Registered highest active level, 0 when none |
| par_err | output | 1 | One-cycle pulse after a write with reserved bits set |

## Verification
The scan is tried with the following patterns:

- A single source shows that each level maps to its own index.
- Several sources at once show that the highest index wins rather than the lowest or the most recent.
- A pattern with bit 0 and bit 15 together shows that bit 0 never enters the set and that the top level is reachable.

Masking a higher level while a lower one stays pending separates a true masked scan from a scan of raw pending bits. Mask writes that try to set bit 15 confirm that level 15 stays unmaskable.

In test mode, forced bits coexist with pending bits at the same level. An acknowledge must then retire the force bit first and the pending bit second, which tells the two clear paths apart. Toggling the test enable with force bits held shows that they drop out of the request and return.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_CLR   = 2'd2,
    SEL_FORCE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_ns = s2_q;
endmodule

// File: rtl/irq_wr_check.sv
module irq_wr_check
  import irq_pkg::*;
#(
  parameter int NLVL = 15,
  parameter int DW   = 32
) (
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          bad_wr
);
  // Bits a write may carry without raising the error.
  localparam logic [DW-1:0] LVL_OK  = {{(DW-NLVL-1){1'b0}}, {NLVL{1'b1}}, 1'b0};
  localparam logic [DW-1:0] MASK_OK = {{(DW-NLVL){1'b0}}, {(NLVL-1){1'b1}}, 1'b0};

  reg_sel_e sel;
  logic     mask_bad;
  logic     lvl_bad;

  always_comb begin
    sel      = reg_sel_e'(wr_sel);
    mask_bad = |(wr_data & ~MASK_OK);
    lvl_bad  = |(wr_data & ~LVL_OK);
    bad_wr   = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_MASK:            bad_wr = mask_bad;
        SEL_CLR, SEL_FORCE:  bad_wr = lvl_bad;
        default:             bad_wr = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int NLVL = 15,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL:0]   src,
  input  logic            test_en,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [NLVL:0]   wr_bits,
  input  logic            ack_valid,
  input  logic [LW-1:0]   ack_level,
  output logic [NLVL:0]   pend_q,
  output logic [NLVL:0]   mask_q,
  output logic [NLVL:0]   frc_q
);
  localparam logic [NLVL:0] LVL_KEEP  = {{NLVL{1'b1}}, 1'b0};
  localparam logic [NLVL:0] MASK_KEEP = {1'b0, {(NLVL-1){1'b1}}, 1'b0};

  logic [NLVL:0] pend_d;
  logic [NLVL:0] mask_d;
  logic [NLVL:0] frc_d;
  logic [NLVL:0] src_m;
  logic          ack_hit;
  logic          upd_en;
  reg_sel_e      sel;

  always_comb begin
    sel     = reg_sel_e'(wr_sel);
    src_m   = src & LVL_KEEP;
    ack_hit = ack_valid && (ack_level != '0) && (int'(ack_level) <= NLVL);
    upd_en  = wr_en | ack_hit | (|src_m);
    pend_d  = pend_q;
    mask_d  = mask_q;
    frc_d   = frc_q;
    if (wr_en) begin
      case (sel)
        SEL_MASK:  mask_d = wr_bits & MASK_KEEP;
        SEL_CLR:   pend_d = pend_d & ~(wr_bits & LVL_KEEP);
        SEL_FORCE: if (test_en) frc_d = wr_bits & LVL_KEEP;
        default:   ;
      endcase
    end
    if (ack_hit) begin
      if (test_en && frc_q[ack_level]) frc_d[ack_level] = 1'b0;
      else                             pend_d[ack_level] = 1'b0;
    end
    // Source sets are applied last so they win over any clear.
    pend_d = pend_d | src_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      frc_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      frc_q  <= frc_d;
    end
  end

  // R4: a source pulse leaves its pending bit set on the next cycle
  a_r4_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_m != '0) |=> ((pend_q & $past(src_m)) == $past(src_m)));

  // R8: with the test enable low the force register cannot change
  a_r8_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> $stable(frc_q));

  // R2: bit 0 of the stored vectors stays clear
  a_r2_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!pend_q[0] && !frc_q[0] && !mask_q[0]));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NLVL = 15,
  parameter int LW   = 4
) (
  input  logic [NLVL:0]  act,
  output logic [LW-1:0]  lvl
);
  // Ascending scan: a later (higher) hit overrides a lower one.
  always_comb begin
    lvl = '0;
    for (int i = 1; i <= NLVL; i++) begin
      if (act[i]) lvl = LW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NLVL = 15,
  parameter int DW   = 32,
  localparam int LW  = $clog2(NLVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NLVL:0]  src_pulse,
  input  logic           test_en,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic [1:0]     rd_sel,
  output logic [DW-1:0]  rd_data,
  input  logic           ack_valid,
  input  logic [LW-1:0]  ack_level,
  output logic [LW-1:0]  irq_level,
  output logic           par_err
);
  logic          rst_ns;
  logic [NLVL:0] pend_q;
  logic [NLVL:0] mask_q;
  logic [NLVL:0] frc_q;
  logic [NLVL:0] act;
  logic [LW-1:0] lvl_nx;
  logic          bad_wr;
  logic [LW-1:0] irl_q;
  logic          err_q;

  irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  irq_regfile #(.NLVL(NLVL), .LW(LW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .src       (src_pulse),
    .test_en   (test_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_bits   (wr_data[NLVL:0]),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .frc_q     (frc_q)
  );

  irq_wr_check #(.NLVL(NLVL), .DW(DW)) u_chk (
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .bad_wr  (bad_wr)
  );

  always_comb begin
    act = (pend_q | (test_en ? frc_q : '0)) & ~mask_q;
    act[0] = 1'b0;
  end

  irq_prio_enc #(.NLVL(NLVL), .LW(LW)) u_enc (
    .act (act),
    .lvl (lvl_nx)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      irl_q <= '0;
      err_q <= 1'b0;
    end else begin
      irl_q <= lvl_nx;
      err_q <= bad_wr;
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_PEND:  rd_data = DW'(pend_q);
      SEL_MASK:  rd_data = DW'(mask_q);
      SEL_FORCE: rd_data = DW'(frc_q);
      default:   rd_data = '0;
    endcase
  end

  assign irq_level = irl_q;
  assign par_err   = err_q;

  // R3: an empty active set gives level 0 one cycle later
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    (act == '0) |=> (irq_level == '0));

  // R3: a non-empty active set gives a non-zero level
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_ns)
    (act != '0) |=> (irq_level != '0));

  // R3: the top level wins whenever it is active
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    act[NLVL] |=> (irq_level == LW'(NLVL)));

  // R9: a mask write with bit 0 set raises the error pulse
  a_r9_mask_bit0: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_sel == 2'd1 && wr_data[0]) |=> par_err);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_pulse;
  logic        test_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        ack_valid;
  logic [3:0]  ack_level;
  logic [3:0]  irq_level;
  logic        par_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .test_en(test_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .par_err(par_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, cycle %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    src_pulse = v;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic ack(input logic [3:0] l);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = l;
    @(negedge clk);
    ack_valid = 1'b0; ack_level = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 level", 32'(irq_level), 0);
    chk("R1 err", 32'(par_err), 0);
    rd(2'd0, v); chk("R1 pending", v, 0);
    rd(2'd1, v); chk("R1 mask", v, 0);
    rd(2'd3, v); chk("R1 force", v, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    pulse(16'h0020);
    rd(2'd0, v); chk("R4 pending set", v, 32'h20);
    settle();
    chk("R3 single level", 32'(irq_level), 5);
    wr(2'd2, 32'hFFFE);
    settle();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    pulse(16'h1208);
    settle();
    chk("R3 highest of 3,9,12", 32'(irq_level), 12);
    pulse(16'h8001);
    rd(2'd0, v); chk("R2 bit0 never stored", v, 32'h9208);
    settle();
    chk("R3 level 15", 32'(irq_level), 15);
    wr(2'd2, 32'h1008);
    chk("R9 legal clear no err", 32'(par_err), 0);
    rd(2'd0, v); chk("R6 partial clear", v, 32'h8200);
    rd(2'd2, v); chk("R10 clear reads 0", v, 0);
    wr(2'd2, 32'hFFFE);
    settle();
    chk("R3 empty gives 0", 32'(irq_level), 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pulse(16'h0240);
    settle();
    chk("R3 level 9", 32'(irq_level), 9);
    wr(2'd1, 32'h0200);
    settle();
    chk("R7 masked 9 gives 6", 32'(irq_level), 6);
    wr(2'd1, 32'hFFFE);
    chk("R9 mask bit15 err", 32'(par_err), 1);
    rd(2'd1, v); chk("R7 mask keeps 14..1", v, 32'h7FFE);
    settle();
    chk("R2 all masked", 32'(irq_level), 0);
    pulse(16'h8000);
    settle();
    chk("R7 level 15 unmaskable", 32'(irq_level), 15);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFE);
    settle();
  endtask

  task automatic t_ack();
    logic [31:0] v;
    pulse(16'h0110);
    settle();
    chk("R3 level 8", 32'(irq_level), 8);
    ack(4'd8);
    rd(2'd0, v); chk("R5 ack clears pending 8", v, 32'h10);
    settle();
    chk("R3 level 4 after ack", 32'(irq_level), 4);
    ack(4'd0);
    rd(2'd0, v); chk("R5 ack 0 no effect", v, 32'h10);
    // Same-cycle set and acknowledge on level 4
    @(negedge clk);
    src_pulse = 16'h0010; ack_valid = 1'b1; ack_level = 4'd4;
    @(negedge clk);
    src_pulse = '0; ack_valid = 1'b0; ack_level = '0;
    rd(2'd0, v); chk("R4 set beats ack", v, 32'h10);
    // Same-cycle set and clear write on level 4
    @(negedge clk);
    src_pulse = 16'h0010; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h10;
    @(negedge clk);
    src_pulse = '0; wr_en = 1'b0; wr_data = '0;
    rd(2'd0, v); chk("R4 set beats clear", v, 32'h10);
    ack(4'd4);
    rd(2'd0, v); chk("R5 ack clears 4", v, 0);
    settle();
  endtask

  task automatic t_force();
    logic [31:0] v;
    test_en = 1'b0;
    wr(2'd3, 32'h0400);
    rd(2'd3, v); chk("R8 force ignored outside test", v, 0);
    settle();
    chk("R8 no level", 32'(irq_level), 0);
    test_en = 1'b1;
    wr(2'd3, 32'h0400);
    rd(2'd3, v); chk("R8 force stored", v, 32'h400);
    settle();
    chk("R2 forced level 10", 32'(irq_level), 10);
    pulse(16'h0400);
    ack(4'd10);
    rd(2'd3, v); chk("R5 force cleared first", v, 0);
    rd(2'd0, v); chk("R5 pending kept", v, 32'h400);
    settle();
    chk("R3 pending still 10", 32'(irq_level), 10);
    ack(4'd10);
    rd(2'd0, v); chk("R5 pending cleared second", v, 0);
    wr(2'd3, 32'h0800);
    test_en = 1'b0;
    settle(); settle();
    chk("R2 force dropped outside test", 32'(irq_level), 0);
    rd(2'd3, v); chk("R8 force held", v, 32'h800);
    test_en = 1'b1;
    settle(); settle();
    chk("R2 force back in test", 32'(irq_level), 11);
    wr(2'd3, 32'h8001_0002);
    chk("R9 force reserved err", 32'(par_err), 1);
    rd(2'd3, v); chk("R9 force legal bits kept", v, 32'h2);
    wr(2'd3, 32'h8000);
    chk("R9 force bit15 legal", 32'(par_err), 0);
    wr(2'd3, 32'h0);
    test_en = 1'b0;
    settle();
  endtask

  task automatic t_perr();
    logic [31:0] v;
    wr(2'd2, 32'h1);
    chk("R9 clear bit0 err", 32'(par_err), 1);
    settle();
    chk("R9 err one cycle", 32'(par_err), 0);
    wr(2'd3, 32'h0001_0000);
    chk("R9 force bit16 err", 32'(par_err), 1);
    wr(2'd1, 32'h0002);
    chk("R9 legal mask no err", 32'(par_err), 0);
    wr(2'd1, 32'h0);
    pulse(16'h0004);
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R10 pending write no err", 32'(par_err), 0);
    rd(2'd0, v); chk("R10 pending write ignored", v, 32'h4);
    wr(2'd2, 32'hFFFE);
  endtask

  initial begin
    rst_n = 1'b0; src_pulse = '0; test_en = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_data = '0; rd_sel = '0; ack_valid = 1'b0; ack_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_ack();
    t_force();
    t_perr();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule